// File: doc/BRIEF.md
# Locking Timestamp Capture Registers

This block holds the hardware event stamps for a network port's precision-time support. A free-running 64-bit time value arrives on an input bus. When the transmit path or the receive path signals that a qualifying packet has crossed the stamping point, the block copies that time into a pair of 32-bit words (low and high) for that direction and raises a valid flag.

Once a direction holds a stamp, it is locked. Further strobes in that direction are dropped, and the stored value stays unchanged. Software releases the lock by reading the high word of the pair. Because of this rule, a stamp can always be tied to the single packet software is waiting on.

The receive side stamps only the packet kinds picked by a type field in its control word. A maskable interrupt reports each new transmit stamp. Software reaches all of this through a simple single-cycle register port with combinational read data.

Top module: `tsc_stamp_capture`

## Requirements
- R1: When a direction is enabled and unlocked and its strobe qualifies, the time value present at that clock edge is stored. Low word = bits 31:0 (transmit address 2, receive address 4); high word = bits 63:32 (transmit address 3, receive address 5). The direction's valid bit (bit 1 of its control word) becomes 1 at the same edge.
- R2: While a direction's valid bit is 1, its strobes are dropped and its stored stamp does not change.
- R3: A read of a direction's high word clears that direction's valid bit at the edge that accepts the read, so the next qualifying strobe is captured.
- R4: A read of a low word leaves the valid bit unchanged.
- R5: With the enable bit (bit 0 of the control word: address 0 transmit, address 1 receive) at 0, strobes are ignored and valid stays 0.
- R6: Receive stamping is selected by the 3-bit type field at bits 6:4 of address 1. The value 0 stamps nothing, 7 stamps every receive strobe, and any other value stamps only strobes whose packet kind equals it. A write to address 1 replaces the whole field.
- R7: Bit 0 of address 6 unmasks the transmit interrupt. When transmit valid is set while unmasked, the cause bit (bit 0 of address 7, driven on `irq`) becomes 1 at that edge. Writing 1 to that bit clears it; a new setting event in the same cycle wins.
- R8: After reset every register reads 0. Control words read enable in bit 0, valid in bit 1 and, for receive, the type field in bits 6:4, with all other bits 0. Valid bits cannot be written.
- R9: The transmit and receive pairs lock, capture and release independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_ns | input | 64 | Current time value to be stamped |
| tx_evt | input | 1 | Transmit packet passed the stamping point |
| rx_evt | input | 1 | Receive packet passed the stamping point |
| rx_kind | input | 3 | Packet kind of the receive strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Transmit stamp interrupt cause |

## Verification
Directed sequences cover five situations:
- A strobe with enable cleared, which separates gating by enable from gating by the lock.
- A second strobe after a capture, which shows whether a locked pair can be overwritten.
- Low-word then high-word reads, which tell a release by any stamp read apart from a release only by the high word.
- Receive strobes of matching and non-matching kinds under type values 0, 7 and a specific kind, which separate the three filter modes and a merging write from a replacing one.
- Masked and unmasked transmit captures with clears, which test the interrupt path.

A long run of seeded random strobes, packet kinds, reads and writes then mixes both directions. It catches cross-direction leakage and same-cycle interactions such as a release read arriving together with a strobe.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TSC_TIME_W = 64;
  localparam int TSC_REG_W  = 32;
  localparam int TSC_ADDR_W = 3;
  localparam int TSC_KIND_W = 3;
  localparam int TSC_NDIR   = 2;

  typedef enum logic [TSC_ADDR_W-1:0] {
    A_TXCTL  = 3'd0,
    A_RXCTL  = 3'd1,
    A_TXLO   = 3'd2,
    A_TXHI   = 3'd3,
    A_RXLO   = 3'd4,
    A_RXHI   = 3'd5,
    A_IMASK  = 3'd6,
    A_ICAUSE = 3'd7
  } tsc_addr_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
endpackage

// File: rtl/tsc_capture_pair.sv
module tsc_capture_pair #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe,
  input  logic              release_rd,
  input  logic [TIME_W-1:0] time_in,
  output logic              valid,
  output logic [TIME_W-1:0] stamp,
  output logic              load
);
  logic              valid_d;
  logic [TIME_W-1:0] stamp_d;

  always_comb begin
    load    = en & strobe & ~valid;
    valid_d = valid;
    stamp_d = stamp;
    if (load) begin
      valid_d = 1'b1;
      stamp_d = time_in;
    end else if (release_rd) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      stamp <= '0;
    end else begin
      valid <= valid_d;
      if (load) stamp <= stamp_d;
    end
  end

  assert_capture_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(en) && $past(strobe)));
  assert_locked_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(stamp));
  assert_hi_read_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && release_rd) |=> !valid);
  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !valid) |=> !valid);
endmodule

// File: rtl/tsc_ctrl_regs.sv
module tsc_ctrl_regs
  import tsc_pkg::*;
#(
  parameter int TIME_W = TSC_TIME_W,
  parameter int REG_W  = TSC_REG_W,
  parameter int ADDR_W = TSC_ADDR_W,
  parameter int KIND_W = TSC_KIND_W,
  parameter int NDIR   = TSC_NDIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NDIR-1:0]   valid,
  input  logic              tx_load,
  input  logic [TIME_W-1:0] tx_stamp,
  input  logic [TIME_W-1:0] rx_stamp,
  output logic [NDIR-1:0]   en,
  output logic [KIND_W-1:0] rx_type,
  output logic [NDIR-1:0]   release_rd,
  output logic              irq,
  output logic [REG_W-1:0]  rdata
);
  localparam int EN_BIT    = 0;
  localparam int VALID_BIT = 1;
  localparam int TYPE_LSB  = 4;

  logic [NDIR-1:0]   en_d;
  logic [KIND_W-1:0] type_d;
  logic              mask_q, mask_d;
  logic              cause_q, cause_d;
  tsc_addr_e         a;

  assign a = tsc_addr_e'(addr);

  always_comb begin
    en_d    = en;
    type_d  = rx_type;
    mask_d  = mask_q;
    cause_d = cause_q;
    if (wr_en) begin
      case (a)
        A_TXCTL:  en_d[DIR_TX] = wdata[EN_BIT];
        A_RXCTL: begin
          en_d[DIR_RX] = wdata[EN_BIT];
          type_d       = wdata[TYPE_LSB +: KIND_W];
        end
        A_IMASK:  mask_d = wdata[0];
        A_ICAUSE: if (wdata[0]) cause_d = 1'b0;
        default: ;
      endcase
    end
    if (tx_load && mask_q) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      rx_type <= '0;
      mask_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      en      <= en_d;
      rx_type <= type_d;
      mask_q  <= mask_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    release_rd         = '0;
    release_rd[DIR_TX] = rd_en && (a == A_TXHI);
    release_rd[DIR_RX] = rd_en && (a == A_RXHI);
  end

  always_comb begin
    rdata = '0;
    case (a)
      A_TXCTL: begin
        rdata[EN_BIT]    = en[DIR_TX];
        rdata[VALID_BIT] = valid[DIR_TX];
      end
      A_RXCTL: begin
        rdata[EN_BIT]                = en[DIR_RX];
        rdata[VALID_BIT]             = valid[DIR_RX];
        rdata[TYPE_LSB +: KIND_W]    = rx_type;
      end
      A_TXLO:   rdata = tx_stamp[REG_W-1:0];
      A_TXHI:   rdata = tx_stamp[REG_W +: REG_W];
      A_RXLO:   rdata = rx_stamp[REG_W-1:0];
      A_RXHI:   rdata = rx_stamp[REG_W +: REG_W];
      A_IMASK:  rdata[0] = mask_q;
      A_ICAUSE: rdata[0] = cause_q;
      default: ;
    endcase
  end

  assign irq = cause_q;

  assert_cause_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && mask_q) |=> irq);
  assert_cause_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a == A_ICAUSE && wdata[0] && !(tx_load && mask_q)) |=> !irq);
  assert_lo_read_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == A_TXLO && valid[DIR_TX]) |=> valid[DIR_TX]);
  assert_onehot_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_rd));
endmodule

// File: rtl/tsc_stamp_capture.sv
module tsc_stamp_capture
  import tsc_pkg::*;
#(
  parameter int TIME_W = TSC_TIME_W,
  parameter int REG_W  = TSC_REG_W,
  parameter int ADDR_W = TSC_ADDR_W,
  parameter int KIND_W = TSC_KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              tx_evt,
  input  logic              rx_evt,
  input  logic [KIND_W-1:0] rx_kind,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int NDIR = TSC_NDIR;
  localparam logic [KIND_W-1:0] KIND_NONE = '0;
  localparam logic [KIND_W-1:0] KIND_ALL  = '1;

  logic                  rst_meta, rst_sync_n;
  logic [NDIR-1:0]       en_v, valid_v, release_v, load_v, strobe_v;
  logic [TIME_W-1:0]     stamp_v [NDIR];
  logic [KIND_W-1:0]     rx_type;
  logic                  rx_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    if (rx_type == KIND_NONE)     rx_qual = 1'b0;
    else if (rx_type == KIND_ALL) rx_qual = 1'b1;
    else                          rx_qual = (rx_kind == rx_type);
  end

  assign strobe_v[DIR_TX] = tx_evt;
  assign strobe_v[DIR_RX] = rx_evt & rx_qual;

  for (genvar d = 0; d < NDIR; d++) begin : g_pair
    tsc_capture_pair #(.TIME_W(TIME_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .en         (en_v[d]),
      .strobe     (strobe_v[d]),
      .release_rd (release_v[d]),
      .time_in    (time_ns),
      .valid      (valid_v[d]),
      .stamp      (stamp_v[d]),
      .load       (load_v[d])
    );
  end

  tsc_ctrl_regs #(
    .TIME_W(TIME_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .KIND_W(KIND_W), .NDIR(NDIR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr),
    .rd_en      (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .valid      (valid_v),
    .tx_load    (load_v[DIR_TX]),
    .tx_stamp   (stamp_v[DIR_TX]),
    .rx_stamp   (stamp_v[DIR_RX]),
    .en         (en_v),
    .rx_type    (rx_type),
    .release_rd (release_v),
    .irq        (irq),
    .rdata      (reg_rdata)
  );

  assert_type_none_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!valid_v[DIR_RX] && rx_type == KIND_NONE) |=> !valid_v[DIR_RX]);
  assert_tx_alone_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!valid_v[DIR_RX] && !rx_evt) |=> !valid_v[DIR_RX]);
endmodule

// File: tb/test_tsc_stamp_capture.sv
`timescale 1ns/1ps
module test_tsc_stamp_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] tbus;
  logic        tx, rx, we, re;
  logic [2:0]  kind, a;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [1:0]  m_en, m_val;
  bit [63:0] m_st [2];
  bit [2:0]  m_type;
  bit        m_mask, m_cause;

  always #2 clk = ~clk;

  tsc_stamp_capture i_tsc_stamp_capture (
    .clk(clk), .rst_n(rst_n), .time_ns(tbus), .tx_evt(tx), .rx_evt(rx),
    .rx_kind(kind), .reg_wr(we), .reg_rd(re), .reg_addr(a), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq)
  );

  function automatic bit [31:0] mread(bit [2:0] ad);
    bit [31:0] v = '0;
    case (ad)
      3'd0: begin v[0] = m_en[0]; v[1] = m_val[0]; end
      3'd1: begin v[0] = m_en[1]; v[1] = m_val[1]; v[6:4] = m_type; end
      3'd2: v = m_st[0][31:0];
      3'd3: v = m_st[0][63:32];
      3'd4: v = m_st[1][31:0];
      3'd5: v = m_st[1][63:32];
      3'd6: v[0] = m_mask;
      default: v[0] = m_cause;
    endcase
    return v;
  endfunction

  function automatic bit rxq(bit [2:0] ty, bit [2:0] k);
    if (ty == 3'd0) return 1'b0;
    if (ty == 3'd7) return 1'b1;
    return k == ty;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit t, bit r, bit [2:0] k, bit w, bit rd, bit [2:0] ad,
                      bit [31:0] d, string tag);
    bit ld0, ld1, nc;
    @(negedge clk);
    tx = t; rx = r; kind = k; we = w; re = rd; a = ad; wd = d;
    tbus = {$urandom, $urandom};
    #1;
    if (rd) check(tag, rdata, mread(ad));
    @(posedge clk);
    ld0 = m_en[0] && !m_val[0] && t;
    ld1 = m_en[1] && !m_val[1] && r && rxq(m_type, k);
    nc  = (ld0 && m_mask) || (m_cause && !(w && ad == 3'd7 && d[0]));
    if (ld0) begin m_val[0] = 1; m_st[0] = tbus; end
    else if (rd && ad == 3'd3) m_val[0] = 0;
    if (ld1) begin m_val[1] = 1; m_st[1] = tbus; end
    else if (rd && ad == 3'd5) m_val[1] = 0;
    if (w) begin
      case (ad)
        3'd0: m_en[0] = d[0];
        3'd1: begin m_en[1] = d[0]; m_type = d[6:4]; end
        3'd6: m_mask = d[0];
        default: ;
      endcase
    end
    m_cause = nc;
    #1;
    check("R7 irq", {31'b0, irq}, {31'b0, m_cause});
  endtask

  task automatic wr(bit [2:0] ad, bit [31:0] d);
    step(0, 0, 0, 1, 0, ad, d, "");
  endtask
  task automatic rd(bit [2:0] ad, string tag);
    step(0, 0, 0, 0, 1, ad, 0, tag);
  endtask
  task automatic tx_hit();
    step(1, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rx_hit(bit [2:0] k);
    step(0, 1, k, 0, 0, 0, 0, "");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0029);
    tx = 0; rx = 0; kind = 0; we = 0; re = 0; a = 0; wd = 0; tbus = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R8: reset state of all registers
    for (int i = 0; i < 8; i++) rd(3'(i), "R8 reset");

    // R5: strobe ignored while disabled
    tx_hit();
    rx_hit(3'd2);
    rd(0, "R5 tx valid stays 0");
    rd(1, "R5 rx valid stays 0");

    // R1: capture on enabled tx; R9: rx untouched
    wr(0, 1);
    tx_hit();
    rd(0, "R1 tx valid set");
    rd(2, "R1 tx low word");
    rd(3'd1, "R9 rx still clear");

    // R2: second strobe dropped; R4: low read keeps lock
    wr(0, 1); tx_hit();
    rd(2, "R2 low unchanged");
    rd(2, "R4 low read again");
    rd(0, "R4 valid still set");
    rd(3, "R3 high read releases");
    rd(0, "R3 valid cleared");
    tx_hit();
    rd(0, "R3 re-armed capture");
    rd(3, "R3 new high word");

    // R6: type field filter
    wr(1, 32'h0000_0031);  // enable, type 3
    rx_hit(3'd2);
    rd(1, "R6 kind mismatch not stamped");
    rx_hit(3'd3);
    rd(1, "R6 kind match stamped");
    rd(5, "R6 release rx");
    wr(1, 32'h0000_0051);
    wr(1, 32'h0000_0021);
    rd(1, "R6 field replaced whole");
    wr(1, 32'h0000_0001);
    rx_hit(3'd0); rx_hit(3'd7);
    rd(1, "R6 type none stamps nothing");
    wr(1, 32'h0000_0071);
    rx_hit(3'd5);
    rd(4, "R6 type all stamped low");
    rd(5, "R6 type all stamped high");
    rd(0, "R9 tx lock unaffected by rx");

    // R7: interrupt masked vs unmasked
    rd(3, "R7 release tx");
    tx_hit();
    rd(7, "R7 masked no cause");
    rd(3, "R7 release tx");
    wr(6, 1);
    tx_hit();
    rd(7, "R7 cause set");
    wr(7, 1);
    rd(7, "R7 cause cleared");
    rd(3, "R7 release tx");
    step(1, 0, 0, 1, 0, 3'd7, 1, "");   // set wins over clear
    rd(7, "R7 set wins");
    wr(7, 1);

    // R8: valid bit not writable
    wr(0, 32'hFFFF_FFFE);
    rd(0, "R8 valid read-only");
    wr(0, 1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit t, r, w, q;
      bit [2:0] k, ad;
      bit [31:0] d;
      int unsigned op;
      t = ($urandom % 10) < 3;
      r = ($urandom % 10) < 3;
      k = 3'($urandom);
      op = $urandom % 10;
      w = 0; q = 0;
      ad = 3'($urandom);
      d = $urandom;
      if (op < 5) q = 1;
      else if (op == 5) begin
        w = 1;
        case ($urandom % 4)
          0: ad = 3'd0;
          1: ad = 3'd1;
          2: ad = 3'd6;
          default: ad = 3'd7;
        endcase
        if (ad != 3'd7 && ($urandom % 4) != 0) d[0] = 1;
      end
      step(t, r, k, w, q, ad,
           d, (ad >= 3'd2 && ad <= 3'd5) ? "R1 random stamp" :
              (ad == 3'd7 ? "R7 random cause" : "R8 random ctl"));
    end

    summary();
    $finish;
  end
endmodule